// File: doc/BRIEF.md
# Dual-Mode Interrupt Pin Controller

This block drives one active-low, open-drain interrupt line whose meaning is chosen by a single configuration bit. In general mode, source event pulses are captured into a sticky status register. The line is pulled low while any captured bit whose source is enabled remains set. A host write of ones to the status register clears those bits, which releases the line.

In suspend-indicator mode the same line shows the hub's USB state. It is pulled low when the hub is unconfigured, or configured and suspended. It is released when the hub is configured and active.

Events keep being captured in both modes, so switching modes loses nothing. All outputs are registered. An input sampled at a rising clock edge is visible on the outputs right after that same edge.

Top module: `irq_pin_ctrl`

## Requirements
- R1: While reset is asserted (asynchronous, active low), the status register reads all zeros and the line is released (`irq_pull_low_o` = 0).
- R2: An event pulse on source bit i sets status bit i at the next rising edge, and the bit stays set until it is cleared, whatever the enable mask or mode.
- R3: A clear write (`clr_we_i` = 1) clears exactly the status bits whose `clr_data_i` bit is 1 and leaves the others unchanged. Data presented without the strobe changes nothing.
- R4: If an event on bit i arrives in the same cycle as a clear of bit i, bit i is set after that edge.
- R5: In general mode (`mode_i` = 0), the line is pulled low after an edge exactly when the updated status ANDed with the enable mask sampled at that edge is nonzero. Set bits whose enable is 0 do not pull the line.
- R6: In general mode, once pulled low the line stays low across cycles without a clear write, and is released only by the clear write that removes the last enabled set bit.
- R7: In suspend-indicator mode (`mode_i` = 1), the line is pulled low after an edge when the sampled `hub_cfg_i` is 0 or `hub_susp_i` is 1. It is released when `hub_cfg_i` = 1 and `hub_susp_i` = 0.
- R8: A change of `mode_i` takes effect at the next rising edge and not before it. Status bits are kept across a mode change, and events are still captured in suspend-indicator mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | NSRC | Per-source event pulses |
| irq_en_i | input | NSRC | Per-source interrupt enable mask |
| clr_we_i | input | 1 | Status clear-write strobe |
| clr_data_i | input | NSRC | Write-one-to-clear data |
| mode_i | input | 1 | 0 = general interrupt, 1 = suspend indicator |
| hub_cfg_i | input | 1 | Hub is configured |
| hub_susp_i | input | 1 | Hub is in USB suspend |
| status_o | output | NSRC | Sticky status register |
| irq_pull_low_o | output | 1 | 1 = pull the open-drain line low |

## Verification
The bench targets an event that lands in the same cycle as a clear of its own bit. A design that gives the clear priority would silently lose that event.

It writes zeros and unrelated ones to the status register. This exposes a design that clears on any write, or that treats the data as write-one-to-set.

A set bit whose enable is off must not pull the line. Enabling that bit later must pull the line without any new event. A design that masks at capture time instead of at the line would fail both checks.

The mode bit is toggled while status is pending, with the line checked both before and after the edge. This catches a mode switch that acts combinationally, a switch that wipes the status, and a suspend decode that inverts the configured or suspended flags.

// File: rtl/irqpin_pkg.sv
package irqpin_pkg;

    typedef enum logic {
        PIN_MODE_GENERAL = 1'b0,
        PIN_MODE_SUSPEND = 1'b1
    } pin_mode_e;

endpackage

// File: rtl/irqpin_status.sv
// Sticky status register, write-one-to-clear, with an event winning over a clear.
module irqpin_status #(
    parameter int NSRC = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt_i,
    input  logic            clr_we_i,
    input  logic [NSRC-1:0] clr_data_i,
    output logic [NSRC-1:0] status_d_o,
    output logic [NSRC-1:0] status_q_o
);

    typedef struct packed {
        logic [NSRC-1:0] bits;
    } status_t;

    status_t         st_d, st_q;
    logic [NSRC-1:0] next_bit;

    for (genvar gi = 0; gi < NSRC; gi++) begin : g_bit
        logic wipe;
        assign wipe         = clr_we_i & clr_data_i[gi];
        assign next_bit[gi] = evt_i[gi] | (st_q.bits[gi] & ~wipe);
    end

    always_comb begin
        st_d      = st_q;
        st_d.bits = next_bit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_d_o = st_d.bits;
    assign status_q_o = st_q.bits;

endmodule

// File: rtl/irqpin_gen_req.sv
// General-mode request: any enabled pending bit.
module irqpin_gen_req #(
    parameter int NSRC = 8
) (
    input  logic [NSRC-1:0] status_i,
    input  logic [NSRC-1:0] irq_en_i,
    output logic            req_o
);

    always_comb begin
        req_o = |(status_i & irq_en_i);
    end

endmodule

// File: rtl/irqpin_susp_req.sv
// Suspend-indicator request: low unless configured and active.
module irqpin_susp_req (
    input  logic hub_cfg_i,
    input  logic hub_susp_i,
    output logic req_o
);

    always_comb begin
        req_o = ~hub_cfg_i | hub_susp_i;
    end

endmodule

// File: rtl/irq_pin_ctrl.sv
module irq_pin_ctrl
    import irqpin_pkg::*;
#(
    parameter int NSRC = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt_i,
    input  logic [NSRC-1:0] irq_en_i,
    input  logic            clr_we_i,
    input  logic [NSRC-1:0] clr_data_i,
    input  logic            mode_i,
    input  logic            hub_cfg_i,
    input  logic            hub_susp_i,
    output logic [NSRC-1:0] status_o,
    output logic            irq_pull_low_o
);

    typedef struct packed {
        logic pull_low;
    } pin_t;

    pin_t            pin_d, pin_q;
    pin_mode_e       mode_sel;
    logic [NSRC-1:0] status_next;
    logic [NSRC-1:0] status_cur;
    logic            gen_req;
    logic            susp_req;

    assign mode_sel = pin_mode_e'(mode_i);

    irqpin_status #(.NSRC(NSRC)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt_i),
        .clr_we_i   (clr_we_i),
        .clr_data_i (clr_data_i),
        .status_d_o (status_next),
        .status_q_o (status_cur)
    );

    irqpin_gen_req #(.NSRC(NSRC)) u_gen (
        .status_i (status_next),
        .irq_en_i (irq_en_i),
        .req_o    (gen_req)
    );

    irqpin_susp_req u_susp (
        .hub_cfg_i  (hub_cfg_i),
        .hub_susp_i (hub_susp_i),
        .req_o      (susp_req)
    );

    always_comb begin
        pin_d = pin_q;
        unique case (mode_sel)
            PIN_MODE_SUSPEND: pin_d.pull_low = susp_req;
            default:          pin_d.pull_low = gen_req;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q <= '0;
        end else begin
            pin_q <= pin_d;
        end
    end

    assign status_o       = status_cur;
    assign irq_pull_low_o = pin_q.pull_low;

endmodule

// File: rtl/irq_pin_ctrl_chk.sv
module irq_pin_ctrl_chk #(
    parameter int NSRC = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC-1:0] evt_i,
    input logic [NSRC-1:0] irq_en_i,
    input logic            clr_we_i,
    input logic [NSRC-1:0] clr_data_i,
    input logic            mode_i,
    input logic            hub_cfg_i,
    input logic            hub_susp_i,
    input logic [NSRC-1:0] status_o,
    input logic            irq_pull_low_o
);

    // R2
    evt_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((status_o & $past(evt_i)) == $past(evt_i)));

    // R2
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_we_i |=> ((status_o & $past(status_o)) == $past(status_o)));

    // R3
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we_i |=> ((status_o & $past(clr_data_i & ~evt_i)) == '0));

    // R5
    gen_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_i |=> (irq_pull_low_o == |(status_o & $past(irq_en_i))));

    // R7
    susp_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_i |=> (irq_pull_low_o == $past(!hub_cfg_i || hub_susp_i)));

    // R8
    mode_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(mode_i) && !clr_we_i && (evt_i == '0)) |=> $stable(status_o));

endmodule

bind irq_pin_ctrl irq_pin_ctrl_chk #(.NSRC(NSRC)) u_chk (.*);

// File: tb/sim_irq_pin_ctrl.sv
module sim_irq_pin_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 4;
    localparam int NVEC       = 19;

    // {evt[4], en[4], we, data[4], mode, cfg, susp, exp_status[4], exp_low}
    localparam logic [20:0] VEC [NVEC] = '{
        {4'h1, 4'hF, 1'b0, 4'h0, 1'b0, 1'b1, 1'b0, 4'h1, 1'b1},
        {4'h0, 4'hF, 1'b0, 4'h0, 1'b0, 1'b1, 1'b0, 4'h1, 1'b1},
        {4'h0, 4'hF, 1'b1, 4'h2, 1'b0, 1'b1, 1'b0, 4'h1, 1'b1},
        {4'h4, 4'hF, 1'b1, 4'h1, 1'b0, 1'b1, 1'b0, 4'h4, 1'b1},
        {4'h4, 4'hF, 1'b1, 4'h4, 1'b0, 1'b1, 1'b0, 4'h4, 1'b1},
        {4'h0, 4'hF, 1'b1, 4'h4, 1'b0, 1'b1, 1'b0, 4'h0, 1'b0},
        {4'h8, 4'h7, 1'b0, 4'h0, 1'b0, 1'b1, 1'b0, 4'h8, 1'b0},
        {4'h0, 4'hF, 1'b0, 4'h0, 1'b0, 1'b1, 1'b0, 4'h8, 1'b1},
        {4'h0, 4'h7, 1'b0, 4'h0, 1'b0, 1'b1, 1'b0, 4'h8, 1'b0},
        {4'h0, 4'hF, 1'b0, 4'h0, 1'b1, 1'b1, 1'b0, 4'h8, 1'b0},
        {4'h0, 4'hF, 1'b0, 4'h0, 1'b1, 1'b1, 1'b1, 4'h8, 1'b1},
        {4'h0, 4'hF, 1'b0, 4'h0, 1'b1, 1'b0, 1'b0, 4'h8, 1'b1},
        {4'h0, 4'hF, 1'b0, 4'h0, 1'b1, 1'b0, 1'b1, 4'h8, 1'b1},
        {4'h2, 4'hF, 1'b0, 4'h0, 1'b1, 1'b1, 1'b0, 4'hA, 1'b0},
        {4'h0, 4'hF, 1'b0, 4'h0, 1'b0, 1'b1, 1'b0, 4'hA, 1'b1},
        {4'h0, 4'hF, 1'b1, 4'hF, 1'b0, 1'b1, 1'b0, 4'h0, 1'b0},
        {4'h1, 4'hF, 1'b0, 4'h0, 1'b0, 1'b1, 1'b0, 4'h1, 1'b1},
        {4'h0, 4'hF, 1'b0, 4'hF, 1'b0, 1'b1, 1'b0, 4'h1, 1'b1},
        {4'h0, 4'hF, 1'b1, 4'h1, 1'b0, 1'b1, 1'b0, 4'h0, 1'b0}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] evt = '0;
    logic [N-1:0] en = '0;
    logic         we = 1'b0;
    logic [N-1:0] data = '0;
    logic         mode = 1'b0;
    logic         cfg = 1'b1;
    logic         susp = 1'b0;
    logic [N-1:0] status;
    logic         low;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_pin_ctrl #(.NSRC(N)) u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .evt_i          (evt),
        .irq_en_i       (en),
        .clr_we_i       (we),
        .clr_data_i     (data),
        .mode_i         (mode),
        .hub_cfg_i      (cfg),
        .hub_susp_i     (susp),
        .status_o       (status),
        .irq_pull_low_o (low)
    );

    function automatic string row_tag(int i);
        case (i)
            0, 1, 16:           return "R2";
            2, 3, 17, 18:       return "R3";
            4:                  return "R4";
            5, 15:              return "R6";
            6, 7, 8:            return "R5";
            9, 10, 11, 12:      return "R7";
            default:            return "R8";
        endcase
    endfunction

    task automatic check(string tag, logic [N-1:0] exp_st, logic exp_low);
        n_run++;
        if (status !== exp_st || low !== exp_low) begin
            n_fail++;
            $display("FAIL %s: status=%h low=%b expected status=%h low=%b",
                     tag, status, low, exp_st, exp_low);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check("R1", '0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        en    = 4'hF;
        step();
        check("R1", '0, 1'b0);

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            evt  = VEC[i][20:17];
            en   = VEC[i][16:13];
            we   = VEC[i][12];
            data = VEC[i][11:8];
            mode = VEC[i][7];
            cfg  = VEC[i][6];
            susp = VEC[i][5];
            step();
            check(row_tag(i), VEC[i][4:1], VEC[i][0]);
        end

        // R8: mode switch acts at the edge, not before it
        @(negedge clk);
        evt = 4'h2; we = 1'b0; mode = 1'b0; en = 4'hF; cfg = 1'b1; susp = 1'b0;
        step();
        check("R8", 4'h2, 1'b1);
        @(negedge clk);
        evt  = '0;
        mode = 1'b1;
        #1;
        check("R8", 4'h2, 1'b1);
        step();
        check("R8", 4'h2, 1'b0);

        // R1: reset in the middle of a run clears everything
        @(negedge clk);
        mode = 1'b0;
        evt  = 4'h5;
        step();
        check("R5", 4'h7, 1'b1);
        @(negedge clk);
        evt   = '0;
        rst_n = 1'b0;
        #1;
        check("R1", '0, 1'b0);
        step();
        check("R1", '0, 1'b0);

        // R7: leaving reset in suspend mode while unconfigured
        @(negedge clk);
        mode  = 1'b1;
        cfg   = 1'b0;
        rst_n = 1'b1;
        step();
        check("R7", '0, 1'b1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule